// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block sits between an 8-bit processor bus and three 8-bit peripheral ports, A, B and C. A chip select and two address bits qualify read and write strobes. The strobes reach one of the three port data latches or the configuration register. The configuration register is called the control word. It splits the 24 pins into two groups of 12. The first group is port A together with the upper nibble of port C. The second group is port B together with the lower nibble of port C. Each group has its own operating mode and its own direction bits. From these the block produces a per-pin output enable.

A write to the control address has two meanings, chosen by data bit 7. With bit 7 set, the write loads a new control word. With bit 7 clear, the write is a single-bit set or clear command on the port C latch. Reads of a port return the driven latch value on output pins and the live pin level on input pins. A read of the control address returns the control word. Pins that a handshake mode lends to a separate sequencing block have their output enable held low here.

Top module: `parport_ctl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the control word to 8'h9B, clears all three port latches and sets every output enable to 0.
- R2: A write takes effect on the rising edge where `cs` and `wr` are both high. `addr` selects the target: 0 is port A, 1 is port B, 2 is port C, 3 is control. With `cs` low, nothing changes.
- R3: A control write with data bit 7 = 1 replaces the control word. A read at address 3 returns the control word exactly.
- R4: Loading a control word clears the A, B and C latches to zero.
- R5: A control write with bit 7 = 0 writes bit 0 into port C latch bit number bits[3:1]. The other C latch bits and the control word are left unchanged.
- R6: Direction bits in the control word are 1 for input and 0 for output. Bit 4 covers port A, bit 1 port B, bit 3 the C upper nibble and bit 0 the C lower nibble. In mode 0 each enable byte or nibble is the inverse of its bit.
- R7: A read of port A, B or C returns, bit by bit, the latch where the pin's output enable is 1 and the input pin where it is 0.
- R8: The group A mode is taken from bits 6:5: 00 is mode 0, 01 is mode 1 and 1x is mode 2. Mode 1 frees PC3, plus PC5:4 when A is an input or PC7:6 when A is an output. Mode 2 frees port A and PC7:3. Freed pins have output enable 0.
- R9: Bit 2 selects group B mode 1. In mode 1, PC2:0 have output enable 0 and port B still follows its direction bit.
- R10: `dout` is 0 unless `cs` and `rd` are both high.
- R11: `pa_out`, `pb_out` and `pc_out` always show the three port latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high, one cycle per write |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B per-pin output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C per-pin output enable |

## Verification
The assertions rely on each write being a plain single-cycle strobe. They also assume that `addr` and `din` are valid whenever `cs` and `wr` are high, so that the cycle after such a strobe can be attributed to it. The bench drives every bus input on the falling clock edge and releases `wr` one cycle later. It never overlaps a read with a write, so every register change traces back to one known command. The pin inputs are set only to values that differ from the latches. That way a read shows which source it selected.

// File: rtl/parport_ctl.sv
module parport_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  localparam logic [7:0] CTRL_RST = 8'h9B;

  logic [7:0] ctrl, lat_a, lat_b, lat_c;
  logic       a_m1, a_m2, b_m1;

  assign a_m2 = ctrl[6];
  assign a_m1 = ctrl[6:5] == 2'b01;
  assign b_m1 = ctrl[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= CTRL_RST;
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (cs && wr) begin
      case (addr)
        2'd0: lat_a <= din;
        2'd1: lat_b <= din;
        2'd2: lat_c <= din;
        default: begin
          if (din[7]) begin
            ctrl  <= din;
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
          end else begin
            lat_c[din[3:1]] <= din[0];
          end
        end
      endcase
    end
  end

  always_comb begin
    pa_oe = a_m2 ? 8'h00 : {8{~ctrl[4]}};
    pb_oe = {8{~ctrl[1]}};
    pc_oe = {{4{~ctrl[3]}}, {4{~ctrl[0]}}};
    if (b_m1) pc_oe[2:0] = 3'b000;
    if (a_m2) pc_oe[7:3] = 5'b00000;
    else if (a_m1) begin
      pc_oe[3] = 1'b0;
      if (ctrl[4]) pc_oe[5:4] = 2'b00;
      else         pc_oe[7:6] = 2'b00;
    end
  end

  assign pa_out = lat_a;
  assign pb_out = lat_b;
  assign pc_out = lat_c;

  always_comb begin
    dout = '0;
    if (cs && rd) begin
      case (addr)
        2'd0: dout = (lat_a & pa_oe) | (pa_in & ~pa_oe);
        2'd1: dout = (lat_b & pb_oe) | (pb_in & ~pb_oe);
        2'd2: dout = (lat_c & pc_oe) | (pc_in & ~pc_oe);
        default: dout = ctrl;
      endcase
    end
  end
endmodule

module parport_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] din,
  input logic [7:0] ctrl,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_oe
);
  AST_RESET_OE_LOW: assert property (@(posedge clk)
    rst |=> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00)); // R1
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(ctrl))); // R2
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd3 && din[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)); // R4
  AST_BSR_KEEPS_CTRL: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd3 && !din[7]) |=> $stable(ctrl)); // R5
  AST_BSR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'd3 && !din[7]) |=> ($countones(pc_out ^ $past(pc_out)) <= 1)); // R5
  AST_MODE2_A_FREED: assert property (@(posedge clk) disable iff (rst)
    ctrl[6] |-> (pa_oe == 8'h00 && pc_oe[7:3] == 5'b00000)); // R8
endmodule

bind parport_ctl parport_chk u_chk (.*);

// File: tb/sim_parport_ctl.sv
module sim_parport_ctl;
  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] din = '0, pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  parport_ctl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; din = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = dout;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_rd(2'd3, d);
    chk("R1 ctrl", d, 8'h9B);
    chk("R1 oe", {pa_oe, pb_oe, pc_oe}, 24'h0);
    chk("R1 latches", {pa_out, pb_out, pc_out}, 24'h0);
  endtask

  task automatic t_modeword;
    logic [7:0] d;
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd3, d);
    chk("R3 readback", d, 8'h80);
    chk("R6 all out", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);
  endtask

  task automatic t_ports;
    logic [7:0] d;
    pa_in = 8'h11;
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'hF0);
    chk("R11 outs", {pa_out, pb_out, pc_out}, 24'h5AC3F0);
    bus_rd(2'd0, d);
    chk("R7 out read", d, 8'h5A);
    bus_wr(2'd0, 8'h00, 1'b0);
    chk("R2 cs low", pa_out, 8'h5A);
    @(negedge clk); #1;
    chk("R10 idle dout", dout, 8'h00);
  endtask

  task automatic t_bsr;
    logic [7:0] d;
    bus_wr(2'd3, 8'h07);
    chk("R5 set bit3", pc_out, 8'hF8);
    bus_wr(2'd3, 8'h0E);
    chk("R5 clear bit7", pc_out, 8'h78);
    bus_rd(2'd3, d);
    chk("R5 ctrl kept", d, 8'h80);
  endtask

  task automatic t_mixed;
    logic [7:0] d;
    bus_wr(2'd3, 8'h98);
    chk("R4 cleared", {pa_out, pb_out, pc_out}, 24'h0);
    chk("R6 mixed oe", {pa_oe, pb_oe, pc_oe}, 24'h00FF0F);
    pa_in = 8'h3C; pc_in = 8'hA5;
    bus_rd(2'd0, d);
    chk("R7 in read", d, 8'h3C);
    bus_wr(2'd2, 8'h06);
    bus_rd(2'd2, d);
    chk("R7 split C", d, 8'hA6);
  endtask

  task automatic t_mode1;
    bus_wr(2'd3, 8'hB4);
    chk("R8 A m1 in", pa_oe, 8'h00);
    chk("R9 B m1", pb_oe, 8'hFF);
    chk("R8 R9 C m1", pc_oe, 8'hC0);
    bus_wr(2'd3, 8'hA0);
    chk("R8 A m1 out", {pa_oe, pc_oe}, 16'hFF37);
  endtask

  task automatic t_mode2;
    bus_wr(2'd3, 8'hC0);
    chk("R8 A m2", {pa_oe, pb_oe, pc_oe}, 24'h00FF07);
    bus_wr(2'd3, 8'hE0);
    chk("R8 A m2 1x", pa_oe, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_modeword();
    t_ports();
    t_bsr();
    t_mixed();
    t_mode1();
    t_mode2();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule